// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block is the register front end of a two-channel bus-master disk DMA controller. A 16-byte I/O window is shared by both channels. One address bit picks the channel, and the three low bits pick a register inside that channel's eight-byte slice. Each slice holds three registers:

- a control register that starts the transfer and sets its direction;
- a status register that mixes software-owned, preserved and write-one-to-clear bits;
- a 32-bit pointer to the descriptor table.

The block exports each channel's start, direction, table base and status to the channel DMA engines. It takes back one-cycle completion and error pulses from those engines.

An access has a size code of one, two or four bytes. Byte j of the write data goes to offset `off+j`, and byte j of the read data comes from offset `off+j`. Both reads and writes are answered one cycle later on a response port. That port carries the read data and an error flag. A rejected access changes no register.

Top module: `bmw_regwin`

## Requirements
- R1: Address bit 3 selects the channel (0 first, 1 second). An access to one channel never changes the other channel's registers or outputs.
- R2: Control register at offset 0. Bit 0 is start and bit 3 is direction, and its other bits read 0. A write that changes start from 0 to 1 sets status bit 0 (active).
- R3: The descriptor table pointer occupies offsets 4 to 7, least significant byte first. Its low two bits always read 0, whatever value is written.
- R4: A one-byte status write at offset 2 loads status bits 6:5 from the written value and leaves bit 0 unchanged. Status bits 7, 4 and 3 always read 0.
- R5: In a status write, each of bits 2 (interrupt) and 1 (error) is cleared where the written value has a 1 and kept where it has a 0.
- R6: Any access of the status register that is not one byte wide is rejected: response error flag 1, read data 0, and no register changes.
- R7: A completion pulse clears status bit 0 and sets status bit 2. It takes priority over a start write and over a status write in the same cycle.
- R8: An error pulse sets status bit 1, and it takes priority over a clearing write in the same cycle.
- R9: Offsets 1 and 3 read as 0, and writes to them change nothing and are not errors.
- R10: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes. Code 3, and any access running past offset 7 of its channel, is rejected as in R6.
- R11: Every read or write is answered exactly one cycle later with response valid. After reset all registers and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Window address: bit 3 channel, bits 2:0 offset |
| io_size | input | 2 | Access size code |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | DATA_W | Write data, byte 0 at the addressed offset |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_err | output | 1 | Access was rejected |
| rsp_data | output | DATA_W | Read data |
| eng_done | input | 2 | Per-channel completion pulse |
| eng_err | input | 2 | Per-channel error pulse |
| dma_start | output | 2 | Per-channel start bit |
| dma_dir | output | 2 | Per-channel direction bit |
| dma_tbl | output | 64 | Per-channel table base, channel 1 in the high word |
| dma_stat | output | 16 | Per-channel status byte, channel 1 in the high byte |

## Verification
The status register is driven with written bytes that mix set and clear bits against several stored states. This separates direct-load bits from preserved and write-one-to-clear bits, and shows whether the reserved bits ever leak. Wide accesses are tried at the table pointer, across the status byte, across the channel end and with the illegal size code. This shows that lanes are routed byte by byte and that a rejected access leaves the registers untouched. Engine pulses are applied to one channel at a time and together with a software write. This shows that the channels are isolated and that the pulses win when they coincide with a write.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
   localparam int unsigned CH_BYTES = 8;
   localparam int unsigned NUM_CH   = 2;
   localparam int unsigned OFF_CMD  = 0;
   localparam int unsigned OFF_STAT = 2;
   localparam int unsigned OFF_TBL  = 4;
   localparam int unsigned TBL_W    = 32;
   localparam int unsigned TBL_B    = TBL_W / 8;

   localparam int unsigned CMD_GO  = 0;
   localparam int unsigned CMD_DIR = 3;
   localparam int unsigned ST_ACT  = 0;
   localparam int unsigned ST_ERR  = 1;
   localparam int unsigned ST_IRQ  = 2;
   localparam int unsigned ST_CAP0 = 5;
   localparam int unsigned ST_CAP1 = 6;

   typedef logic [7:0] byte_t;
   typedef byte_t [CH_BYTES-1:0] chan_bytes_t;
endpackage

// File: rtl/bmw_access_dec.sv
module bmw_access_dec
   import bmw_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [2:0]          off,
   input  logic [1:0]          size,
   input  logic [DATA_W-1:0]   wdata,
   input  chan_bytes_t         rbytes,
   output logic [CH_BYTES-1:0] hit,
   output chan_bytes_t         wbytes,
   output logic [DATA_W-1:0]   rdata,
   output logic                bad
);
   localparam int unsigned LANES = DATA_W / 8;

   logic [3:0] nbytes;
   logic [3:0] end_pos;
   logic [3:0] off4;

   always_comb begin
      off4    = {1'b0, off};
      nbytes  = 4'd1 << size;
      end_pos = off4 + nbytes;
      bad = (size == 2'd3)
         || (nbytes > 4'(LANES))
         || (end_pos > 4'(CH_BYTES))
         || ((off4 <= 4'(OFF_STAT)) && (end_pos > 4'(OFF_STAT)) && (nbytes != 4'd1));
      hit    = '0;
      wbytes = '0;
      rdata  = '0;
      for (int j = 0; j < int'(LANES); j++) begin
         if ((4'(j) < nbytes) && ((off4 + 4'(j)) < 4'(CH_BYTES))) begin
            hit[off + 3'(j)]    = 1'b1;
            wbytes[off + 3'(j)] = wdata[j*8 +: 8];
            rdata[j*8 +: 8]     = rbytes[off + 3'(j)];
         end
      end
   end
endmodule

// File: rtl/bmw_chan.sv
module bmw_chan
   import bmw_pkg::*;
#(
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [CH_BYTES-1:0] hit,
   input  chan_bytes_t         wbytes,
   input  logic                done,
   input  logic                err,
   output chan_bytes_t         rbytes,
   output logic                go,
   output logic                dir,
   output logic [TBL_W-1:0]    tbl,
   output logic [7:0]          stat
);
   localparam logic [TBL_W-1:0] KEEP_MASK = ~((TBL_W'(1) << ALIGN_BITS) - TBL_W'(1));

   logic             st_act, st_err, st_irq;
   logic [1:0]       st_cap;
   logic [TBL_W-1:0] tbl_d;

   always_comb begin
      tbl_d = tbl;
      for (int t = 0; t < int'(TBL_B); t++) begin
         if (wr && hit[OFF_TBL + t]) tbl_d[t*8 +: 8] = wbytes[OFF_TBL + t];
      end
      tbl_d = tbl_d & KEEP_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go     <= 1'b0;
         dir    <= 1'b0;
         st_act <= 1'b0;
         st_err <= 1'b0;
         st_irq <= 1'b0;
         st_cap <= 2'b00;
         tbl    <= '0;
      end else begin
         tbl <= tbl_d;
         if (wr && hit[OFF_CMD]) begin
            go  <= wbytes[OFF_CMD][CMD_GO];
            dir <= wbytes[OFF_CMD][CMD_DIR];
            if (wbytes[OFF_CMD][CMD_GO] && !go) st_act <= 1'b1;
         end
         if (wr && hit[OFF_STAT]) begin
            st_cap <= wbytes[OFF_STAT][ST_CAP1:ST_CAP0];
            if (wbytes[OFF_STAT][ST_ERR]) st_err <= 1'b0;
            if (wbytes[OFF_STAT][ST_IRQ]) st_irq <= 1'b0;
         end
         if (err) st_err <= 1'b1;
         if (done) begin
            st_act <= 1'b0;
            st_irq <= 1'b1;
         end
      end
   end

   always_comb begin
      stat = '0;
      stat[ST_ACT]          = st_act;
      stat[ST_ERR]          = st_err;
      stat[ST_IRQ]          = st_irq;
      stat[ST_CAP1:ST_CAP0] = st_cap;
      rbytes = '0;
      rbytes[OFF_CMD][CMD_GO]  = go;
      rbytes[OFF_CMD][CMD_DIR] = dir;
      rbytes[OFF_STAT]         = stat;
      for (int t = 0; t < int'(TBL_B); t++) rbytes[OFF_TBL + t] = tbl[t*8 +: 8];
   end
endmodule

// File: rtl/bmw_regwin.sv
module bmw_regwin
   import bmw_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [3:0]           io_addr,
   input  logic [1:0]           io_size,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic [DATA_W-1:0]    io_wdata,
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [DATA_W-1:0]    rsp_data,
   input  logic [1:0]           eng_done,
   input  logic [1:0]           eng_err,
   output logic [1:0]           dma_start,
   output logic [1:0]           dma_dir,
   output logic [2*TBL_W-1:0]   dma_tbl,
   output logic [15:0]          dma_stat
);
   if ((DATA_W % 8 != 0) || (DATA_W < 8) || (DATA_W > 32)) begin : g_bad_dw
      $error("DATA_W must be 8, 16 or 32");
   end
   if (ALIGN_BITS > 8) begin : g_bad_al
      $error("ALIGN_BITS must not exceed 8");
   end

   logic [CH_BYTES-1:0] hit;
   chan_bytes_t         wbytes;
   chan_bytes_t         rb_ch [NUM_CH];
   chan_bytes_t         rb_sel;
   logic [DATA_W-1:0]   rdata;
   logic                bad;

   assign rb_sel = rb_ch[io_addr[3]];

   bmw_access_dec #(.DATA_W(DATA_W)) u_dec (
      .off    (io_addr[2:0]),
      .size   (io_size),
      .wdata  (io_wdata),
      .rbytes (rb_sel),
      .hit    (hit),
      .wbytes (wbytes),
      .rdata  (rdata),
      .bad    (bad)
   );

   for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
      logic ch_wr;
      assign ch_wr = io_wr && !bad && (io_addr[3] == 1'(c));
      bmw_chan #(.ALIGN_BITS(ALIGN_BITS)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr     (ch_wr),
         .hit    (hit),
         .wbytes (wbytes),
         .done   (eng_done[c]),
         .err    (eng_err[c]),
         .rbytes (rb_ch[c]),
         .go     (dma_start[c]),
         .dir    (dma_dir[c]),
         .tbl    (dma_tbl[c*TBL_W +: TBL_W]),
         .stat   (dma_stat[c*8 +: 8])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= io_rd || io_wr;
         rsp_err   <= (io_rd || io_wr) && bad;
         rsp_data  <= (io_rd && !bad) ? rdata : '0;
      end
   end
endmodule

// File: rtl/bmw_chk.sv
module bmw_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ALIGN_BITS = 2
) (
   input logic        clk,
   input logic        rst_n,
   input logic [3:0]  io_addr,
   input logic [1:0]  io_size,
   input logic        io_wr,
   input logic        io_rd,
   input logic        rsp_valid,
   input logic        rsp_err,
   input logic [1:0]  eng_done,
   input logic [1:0]  eng_err,
   input logic [1:0]  dma_start,
   input logic [1:0]  dma_dir,
   input logic [63:0] dma_tbl,
   input logic [15:0] dma_stat
);
   localparam logic [31:0] LOW_MASK = (32'd1 << ALIGN_BITS) - 32'd1;

   logic [3:0] n_b, last_b;
   logic       rej;
   always_comb begin
      n_b    = 4'd1 << io_size;
      last_b = {1'b0, io_addr[2:0]} + n_b;
      rej = (io_size == 2'd3) || (int'(n_b) > int'(DATA_W / 8)) || (last_b > 4'd8)
         || ((io_addr[2:0] <= 3'd2) && (last_b > 4'd2) && (n_b != 4'd1));
   end

   p_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd || io_wr) |=> rsp_valid);
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd || io_wr) |=> !rsp_valid);
   p_rej_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((io_rd || io_wr) && rej) |=> rsp_err);
   p_rej_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && rej && (eng_done == 2'b00) && (eng_err == 2'b00))
      |=> ($stable(dma_stat) && $stable(dma_tbl) && $stable(dma_start) && $stable(dma_dir)));

   for (genvar c = 0; c < 2; c++) begin : g_c
      p_tbl_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (dma_tbl[c*32 +: 32] & LOW_MASK) == 32'd0);
      p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
         eng_done[c] |=> (!dma_stat[c*8] && dma_stat[c*8+2]));
      p_err_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
         eng_err[c] |=> dma_stat[c*8+1]);
      p_go_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(dma_start[c]) && !$past(eng_done[c])) |-> dma_stat[c*8]);
   end
endmodule

bind bmw_regwin bmw_chk #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_addr   (io_addr),
   .io_size   (io_size),
   .io_wr     (io_wr),
   .io_rd     (io_rd),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .eng_done  (eng_done),
   .eng_err   (eng_err),
   .dma_start (dma_start),
   .dma_dir   (dma_dir),
   .dma_tbl   (dma_tbl),
   .dma_stat  (dma_stat)
);

// File: tb/sim_bmw_regwin.sv
`timescale 1ns/1ps
module sim_bmw_regwin;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  io_addr = '0;
   logic [1:0]  io_size = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [31:0] io_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_data;
   logic [1:0]  eng_done = '0;
   logic [1:0]  eng_err = '0;
   logic [1:0]  dma_start, dma_dir;
   logic [63:0] dma_tbl;
   logic [15:0] dma_stat;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   bmw_regwin u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
      .eng_done(eng_done), .eng_err(eng_err), .dma_start(dma_start),
      .dma_dir(dma_dir), .dma_tbl(dma_tbl), .dma_stat(dma_stat)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic acc(input logic w, input logic [3:0] a, input logic [1:0] s,
                      input logic [31:0] d, output logic [31:0] q, output logic e);
      @(negedge clk);
      io_addr = a; io_size = s; io_wdata = d; io_wr = w; io_rd = !w;
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0;
      q = rsp_data; e = rsp_err;
      chk("R11 rsp_valid", 64'(rsp_valid), 64'd1);
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d,
                     input logic exp_err, input string tag);
      logic [31:0] q; logic e;
      acc(1'b1, a, s, d, q, e);
      chk(tag, 64'(e), 64'(exp_err));
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [1:0] s, input logic [31:0] exp,
                         input logic exp_err, input string tag);
      logic [31:0] q; logic e;
      acc(1'b0, a, s, 32'd0, q, e);
      chk(tag, {31'd0, e, q}, {31'd0, exp_err, exp});
   endtask

   task automatic pulse(input logic [1:0] dn, input logic [1:0] er);
      @(negedge clk);
      eng_done = dn; eng_err = er;
      @(negedge clk);
      eng_done = '0; eng_err = '0;
   endtask

   task automatic t_reset;
      chk("R11 reset outputs", {dma_stat, dma_start, dma_dir, 28'd0}, 64'd0);
      chk("R11 reset tbl", dma_tbl, 64'd0);
      rd_chk(4'h2, 2'd0, 32'd0, 1'b0, "R11 reset status read");
   endtask

   task automatic t_cmd;
      wr(4'h0, 2'd0, 32'hFF, 1'b0, "R2 cmd write");
      chk("R2 start/dir", {dma_start, dma_dir}, 64'b0101);
      chk("R2 active set", 64'(dma_stat), 64'h0001);
      rd_chk(4'h0, 2'd0, 32'h09, 1'b0, "R2 cmd readback");
      chk("R1 other channel untouched", 64'({dma_start[1], dma_dir[1], dma_stat[15:8]}), 64'd0);
   endtask

   task automatic t_tbl;
      wr(4'hC, 2'd2, 32'h12345677, 1'b0, "R10 wide tbl write");
      chk("R3 tbl aligned ch1", dma_tbl, {32'h12345674, 32'd0});
      rd_chk(4'hE, 2'd1, 32'h1234, 1'b0, "R3 tbl upper half");
      rd_chk(4'hC, 2'd0, 32'h74, 1'b0, "R3 tbl low byte");
      rd_chk(4'h4, 2'd2, 32'h0, 1'b0, "R1 ch0 tbl untouched");
   endtask

   task automatic t_stat;
      pulse(2'b00, 2'b01);
      chk("R8 error event", 64'(dma_stat), 64'h0003);
      pulse(2'b01, 2'b00);
      chk("R7 done event", 64'(dma_stat), 64'h0006);
      wr(4'h2, 2'd0, 32'h64, 1'b0, "R4 status write");
      chk("R5 irq cleared err kept cap set", 64'(dma_stat), 64'h0062);
      wr(4'h0, 2'd0, 32'h00, 1'b0, "R2 stop");
      wr(4'h0, 2'd0, 32'h01, 1'b0, "R2 restart");
      chk("R2 active after restart", 64'(dma_stat), 64'h0063);
      wr(4'h2, 2'd0, 32'h9B, 1'b0, "R5 status write");
      chk("R4 R5 active kept err cleared reserved zero", 64'(dma_stat), 64'h0001);
      rd_chk(4'h2, 2'd0, 32'h01, 1'b0, "R4 status read");
   endtask

   task automatic t_unused;
      wr(4'h1, 2'd0, 32'hFF, 1'b0, "R9 write offset 1");
      wr(4'h3, 2'd0, 32'hFF, 1'b0, "R9 write offset 3");
      rd_chk(4'h1, 2'd0, 32'h0, 1'b0, "R9 read offset 1");
      rd_chk(4'h3, 2'd0, 32'h0, 1'b0, "R9 read offset 3");
      rd_chk(4'h0, 2'd0, 32'h01, 1'b0, "R9 cmd unchanged");
      chk("R9 status unchanged", 64'(dma_stat), 64'h0001);
   endtask

   task automatic t_bad;
      wr(4'h2, 2'd1, 32'hFFFF, 1'b1, "R6 wide status write");
      chk("R6 status unchanged", 64'(dma_stat), 64'h0001);
      wr(4'h0, 2'd2, 32'hFFFFFFFF, 1'b1, "R6 dword over status");
      rd_chk(4'h0, 2'd0, 32'h01, 1'b0, "R6 cmd unchanged");
      rd_chk(4'h2, 2'd1, 32'h0, 1'b1, "R6 wide status read");
      wr(4'h6, 2'd2, 32'hAAAAAAAA, 1'b1, "R10 crossing write");
      wr(4'h4, 2'd3, 32'hAAAAAAAA, 1'b1, "R10 size code 3");
      chk("R10 tbl unchanged", dma_tbl, {32'h12345674, 32'd0});
   endtask

   task automatic t_ch1;
      pulse(2'b10, 2'b00);
      chk("R1 done on ch1 only", 64'(dma_stat), 64'h0401);
      wr(4'hA, 2'd0, 32'h04, 1'b0, "R5 ch1 irq clear");
      chk("R5 ch1 irq cleared", 64'(dma_stat), 64'h0001);
      @(negedge clk);
      io_addr = 4'h8; io_size = 2'd0; io_wdata = 32'h01; io_wr = 1'b1; eng_done = 2'b10;
      @(negedge clk);
      io_wr = 1'b0; eng_done = 2'b00;
      chk("R7 done beats start", 64'(dma_stat), 64'h0401);
      chk("R2 ch1 start stored", 64'(dma_start), 64'b11);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cmd();
      t_tbl();
      t_stat();
      t_unused();
      t_bad();
      t_ch1();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule